// File: doc/BRIEF.md
# Banked Indexed Configuration Register File

This block is the device side of a configuration space reached through two byte-wide I/O ports. Software writes a register number to the index port, then reads or writes the chosen register through the data port one address above it. A few global registers are shared by every function of the chip. A larger set of per-function registers is banked, and a bank-select register picks which function's bank the data port reaches.

The block drives decoded controls straight from its registers. These are a function-enable bitmap, a clock-frequency select bit and one activate bit per function bank. Accesses take effect only while the external configuration-mode request is high. A write to the command register with the leave bit set ends the session, and the block then refuses accesses until the request input has been dropped and raised again.

Top module: `cfg_regfile`

## Requirements
- R1: After reset every register and decoded output is 0, the bank select reads back 0x00, and `cfg_active_o` is low.
- R2: The index port answers at `BASE_ADDR` (default 0x3F0) and the data port at `BASE_ADDR`+1. Strobes to any other address change nothing, and reads there return 0xFF.
- R3: While `cfg_active_o` is low, writes change no register and every read returns 0xFF. `cfg_active_o` equals `cfg_mode_i` unless a leave command has been taken during the current request.
- R4: Register 0x07 holds the bank select. Registers 0x30 to 0x3F reach the bank whose number equals it, and each bank keeps its own 16 bytes.
- R5: Register 0x02 is the command register and always reads 0x00. A write with bit 1 set drops `cfg_active_o` from the next cycle until `cfg_mode_i` has been low for at least one clock. A write with bit 1 clear has no effect.
- R6: Register 0x23 is the enable bitmap driven on `dev_en_o`. Bits 4 and 7 read 0 and ignore writes, so a write of 0xFF gives 0x6F.
- R7: Bit 6 of register 0x24 drives `clk48_sel_o`. The other bits of that register read 0.
- R8: `dev_act_o[n]` is bit 0 of register 0x30 in bank n. It changes only on a data-port write.
- R9: When the bank select is `NUM_BANKS` or more, writes to 0x30 to 0x3F are ignored and reads of them return 0x00.
- R10: Register numbers with no meaning read 0x00, and writes to them are ignored.
- R11: Writes take effect at the clock edge that ends the strobe. Read data is combinational during `io_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode_i | input | 1 | Configuration-mode request |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (0xFF when not answering) |
| cfg_active_o | output | 1 | Accesses are being accepted |
| dev_en_o | output | 8 | Function-enable bitmap |
| clk48_sel_o | output | 1 | High selects the 48 MHz input clock, low the 24 MHz default |
| dev_act_o | output | NUM_BANKS | Per-bank activate bits |

## Verification
Most internal faults show at the ports one clock after the write that causes them. A wrongly held index or bank select sends the next data-port read to the wrong byte, and that read returns the wrong value at once. A lost or stuck leave flag shows on `cfg_active_o` on the cycle after the command, and a 0xFF read then appears where a register value is expected. A bank write that lands in the wrong bank shows on `dev_act_o` right away when it hits offset 0x30. At any other offset it stays hidden until that bank is read back, so the random phase reads every bank offset after many mixed writes.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam logic [7:0] IDX_CMD    = 8'h02;
    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_DEVEN  = 8'h23;
    localparam logic [7:0] IDX_CLKSEL = 8'h24;
    localparam int         BANK_BASE  = 'h30;
    localparam logic [7:0] DEVEN_MASK = 8'h6F;
    localparam int         CLK_BIT    = 6;
    localparam int         LEAVE_BIT  = 1;
    localparam logic [7:0] FLOAT_BYTE = 8'hFF;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] ldn;
        logic [7:0] dev_en;
        logic       clk48;
        logic       leave_hold;
    } glob_state_t;
endpackage

// File: rtl/cfg_port_dec.sv
module cfg_port_dec #(
    parameter logic [15:0] BASE_ADDR = 16'h03F0
) (
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic        active,
    output logic        idx_wr,
    output logic        dat_wr,
    output logic        idx_rd,
    output logic        dat_rd
);
    localparam logic [15:0] DATA_ADDR = BASE_ADDR + 16'd1;

    logic hit_idx, hit_dat;

    always_comb begin
        hit_idx = active && (io_addr == BASE_ADDR);
        hit_dat = active && (io_addr == DATA_ADDR);
        idx_wr  = io_wr && hit_idx;
        dat_wr  = io_wr && hit_dat;
        idx_rd  = io_rd && hit_idx;
        dat_rd  = io_rd && hit_dat;
    end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
    parameter int REGS  = 16,
    localparam int OFS_W = $clog2(REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [OFS_W-1:0] ofs,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             act_o
);
    logic [7:0] regs_d [REGS];
    logic [7:0] regs_q [REGS];

    always_comb begin
        for (int i = 0; i < REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[ofs] = wdata;
        end
        rdata = regs_q[ofs];
        act_o = regs_q[0][0];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < REGS; i++) begin
            if (!rst_n) regs_q[i] <= '0;
            else        regs_q[i] <= regs_d[i];
        end
    end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h03F0,
    parameter int          NUM_BANKS = 8,
    parameter int          BANK_REGS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_mode_i,
    input  logic [15:0]          io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    output logic                 cfg_active_o,
    output logic [7:0]           dev_en_o,
    output logic                 clk48_sel_o,
    output logic [NUM_BANKS-1:0] dev_act_o
);
    localparam int OFS_W    = $clog2(BANK_REGS);
    localparam int BANK_END = BANK_BASE + BANK_REGS;

    glob_state_t st_d, st_q;
    logic        active;
    logic        idx_wr, dat_wr, idx_rd, dat_rd;
    logic        in_bank, ldn_ok;
    logic [OFS_W-1:0] bank_ofs;
    logic [7:0]  bank_rd [NUM_BANKS];
    logic [7:0]  bank_sel_rd;
    logic [NUM_BANKS-1:0] bank_we;
    logic [7:0]  cur_idx, cur_ldn;

    assign active  = cfg_mode_i && !st_q.leave_hold;
    assign cur_idx = st_q.index;
    assign cur_ldn = st_q.ldn;

    cfg_port_dec #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .active  (active),
        .idx_wr  (idx_wr),
        .dat_wr  (dat_wr),
        .idx_rd  (idx_rd),
        .dat_rd  (dat_rd)
    );

    always_comb begin
        in_bank  = (int'(st_q.index) >= BANK_BASE) && (int'(st_q.index) < BANK_END);
        bank_ofs = OFS_W'(int'(st_q.index) - BANK_BASE);
        ldn_ok   = int'(st_q.ldn) < NUM_BANKS;
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign bank_we[g] = dat_wr && in_bank && ldn_ok && (st_q.ldn == 8'(g));
        cfg_bank #(.REGS(BANK_REGS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[g]),
            .ofs   (bank_ofs),
            .wdata (io_wdata),
            .rdata (bank_rd[g]),
            .act_o (dev_act_o[g])
        );
    end

    always_comb begin
        bank_sel_rd = 8'h00;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (st_q.ldn == 8'(i)) bank_sel_rd = bank_rd[i];
        end
    end

    // next-state and read path
    always_comb begin
        st_d = st_q;
        if (idx_wr) st_d.index = io_wdata;
        if (dat_wr) begin
            unique case (st_q.index)
                IDX_CMD:    if (io_wdata[LEAVE_BIT]) st_d.leave_hold = 1'b1;
                IDX_LDN:    st_d.ldn    = io_wdata;
                IDX_DEVEN:  st_d.dev_en = io_wdata & DEVEN_MASK;
                IDX_CLKSEL: st_d.clk48  = io_wdata[CLK_BIT];
                default:    ;
            endcase
        end
        if (!cfg_mode_i) st_d.leave_hold = 1'b0;

        io_rdata = FLOAT_BYTE;
        if (idx_rd) begin
            io_rdata = st_q.index;
        end else if (dat_rd) begin
            io_rdata = 8'h00;
            if (in_bank) begin
                if (ldn_ok) io_rdata = bank_sel_rd;
            end else begin
                unique case (st_q.index)
                    IDX_LDN:    io_rdata = st_q.ldn;
                    IDX_DEVEN:  io_rdata = st_q.dev_en;
                    IDX_CLKSEL: io_rdata[CLK_BIT] = st_q.clk48;
                    default:    io_rdata = 8'h00;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_active_o = active;
    assign dev_en_o     = st_q.dev_en;
    assign clk48_sel_o  = st_q.clk48;
endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk #(
    parameter logic [15:0] BASE_ADDR = 16'h03F0,
    parameter int          NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 io_wr,
    input logic                 io_rd,
    input logic [15:0]          io_addr,
    input logic [7:0]           io_wdata,
    input logic [7:0]           io_rdata,
    input logic                 cfg_active_o,
    input logic [7:0]           dev_en_o,
    input logic                 clk48_sel_o,
    input logic [NUM_BANKS-1:0] dev_act_o,
    input logic [7:0]           cur_idx,
    input logic [7:0]           cur_ldn
);
    a_r3_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_active_o |=> ($stable(dev_en_o) && $stable(clk48_sel_o) && $stable(dev_act_o)));

    a_r3_idle_reads_float: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !cfg_active_o) |-> (io_rdata == 8'hFF));

    a_r5_leave_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_active_o && io_wr && io_addr == BASE_ADDR + 16'd1 && cur_idx == 8'h02 && io_wdata[1])
        |=> !cfg_active_o);

    a_r6_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_en_o[4] == 1'b0) && (dev_en_o[7] == 1'b0));

    a_r8_act_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(dev_act_o));

    a_r9_bad_bank_no_act: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cur_ldn) >= NUM_BANKS) |=> $stable(dev_act_o));
endmodule

bind cfg_regfile cfg_regfile_chk #(.BASE_ADDR(BASE_ADDR), .NUM_BANKS(NUM_BANKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_addr      (io_addr),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .cfg_active_o (cfg_active_o),
    .dev_en_o     (dev_en_o),
    .clk48_sel_o  (clk48_sel_o),
    .dev_act_o    (dev_act_o),
    .cur_idx      (cur_idx),
    .cur_ldn      (cur_ldn)
);

// File: tb/cfg_regfile_test.sv
`timescale 1ns/1ps
module cfg_regfile_test;
    localparam logic [15:0] BASE = 16'h03F0;
    localparam int NB = 8;

    logic        clk = 0, rst_n = 0, cfg_mode = 0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 0, io_rd = 0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_active;
    logic [7:0]  dev_en;
    logic        clk48;
    logic [NB-1:0] dev_act;

    int n_tests = 0, n_fail = 0;

    cfg_regfile #(.BASE_ADDR(BASE), .NUM_BANKS(NB), .BANK_REGS(16)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_active_o(cfg_active), .dev_en_o(dev_en), .clk48_sel_o(clk48),
        .dev_act_o(dev_act)
    );

    always #2 clk = ~clk;

    // reference model
    logic [7:0] m_idx, m_ldn, m_en;
    logic       m_clk, m_hold;
    logic [7:0] m_bank [NB][16];

    function automatic logic m_active();
        return cfg_mode && !m_hold;
    endfunction

    function automatic logic [7:0] exp_rd(logic [15:0] a);
        if (!m_active()) return 8'hFF;
        if (a == BASE) return m_idx;
        if (a != BASE + 16'd1) return 8'hFF;
        if (m_idx >= 8'h30 && m_idx <= 8'h3F)
            return (m_ldn < NB) ? m_bank[m_ldn][m_idx - 8'h30] : 8'h00;
        case (m_idx)
            8'h07: return m_ldn;
            8'h23: return m_en;
            8'h24: return {1'b0, m_clk, 6'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [NB-1:0] exp_act();
        logic [NB-1:0] v;
        for (int i = 0; i < NB; i++) v[i] = m_bank[i][0][0];
        return v;
    endfunction

    task automatic model_wr(logic [15:0] a, logic [7:0] d);
        if (!m_active()) return;
        if (a == BASE) m_idx = d;
        else if (a == BASE + 16'd1) begin
            if (m_idx >= 8'h30 && m_idx <= 8'h3F) begin
                if (m_ldn < NB) m_bank[m_ldn][m_idx - 8'h30] = d;
            end else case (m_idx)
                8'h02: if (d[1]) m_hold = 1;
                8'h07: m_ldn = d;
                8'h23: m_en = d & 8'h6F;
                8'h24: m_clk = d[6];
                default: ;
            endcase
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outs(string req);
        chk(req, {31'b0, cfg_active}, {31'b0, m_active()});
        chk(req, {24'b0, dev_en}, {24'b0, m_en});
        chk(req, {31'b0, clk48}, {31'b0, m_clk});
        chk(req, 32'(dev_act), 32'(exp_act()));
    endtask

    task automatic do_wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1;
        model_wr(a, d);
        @(negedge clk);
        io_wr = 0;
    endtask

    task automatic do_rd(logic [15:0] a, string req);
        @(negedge clk);
        io_addr = a; io_rd = 1;
        #1;
        chk(req, {24'b0, io_rdata}, {24'b0, exp_rd(a)});
        io_rd = 0;
    endtask

    task automatic set_mode(logic v);
        @(negedge clk);
        cfg_mode = v;
        if (!v) m_hold = 0;
        @(negedge clk);
    endtask

    task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
        do_wr(BASE, idx);
        do_wr(BASE + 16'd1, d);
    endtask

    task automatic reg_rd(logic [7:0] idx, string req);
        do_wr(BASE, idx);
        do_rd(BASE + 16'd1, req);
    endtask

    initial begin
        #(4 * 190000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] pick;
        void'($urandom(32'h5EED1234));
        m_idx = 0; m_ldn = 0; m_en = 0; m_clk = 0; m_hold = 0;
        for (int b = 0; b < NB; b++) for (int r = 0; r < 16; r++) m_bank[b][r] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_outs("R1 reset outputs");
        do_rd(BASE + 16'd1, "R3 idle read floats");
        // R3: idle writes ignored
        reg_wr(8'h23, 8'hFF);
        check_outs("R3 idle write ignored");
        set_mode(1);
        check_outs("R3 active follows mode");
        reg_rd(8'h07, "R1 bank select resets 0");
        reg_rd(8'h23, "R3 idle write left bitmap 0");
        // R2: off-address strobes
        do_wr(BASE, 8'h24);
        do_wr(BASE + 16'd2, 8'h55);
        do_wr(BASE - 16'd1, 8'h66);
        do_rd(BASE, "R2 index kept after stray writes");
        do_rd(BASE - 16'd1, "R2 other address floats");
        do_rd(16'h0279, "R2 other address floats");
        // R6 / R11
        reg_wr(8'h23, 8'hFF);
        check_outs("R6 reserved bits masked");
        do_rd(BASE + 16'd1, "R6 bitmap readback 0x6F");
        // R7
        reg_wr(8'h24, 8'hFF);
        check_outs("R7 clock select set");
        do_rd(BASE + 16'd1, "R7 readback 0x40");
        reg_wr(8'h24, 8'hBF);
        check_outs("R7 clock select clear");
        // R4 / R8
        reg_wr(8'h07, 8'd3);
        reg_wr(8'h30, 8'h01);
        check_outs("R8 activate bank 3");
        reg_wr(8'h3F, 8'hA5);
        reg_wr(8'h07, 8'd5);
        reg_rd(8'h3F, "R4 bank 5 separate from bank 3");
        reg_rd(8'h30, "R4 bank 5 offset 0x30");
        reg_wr(8'h07, 8'd3);
        reg_rd(8'h3F, "R4 bank 3 keeps 0xA5");
        // R9
        reg_wr(8'h07, 8'd9);
        reg_wr(8'h30, 8'h01);
        check_outs("R9 out-of-range bank ignored");
        do_rd(BASE + 16'd1, "R9 out-of-range reads 0");
        // R10
        reg_wr(8'h50, 8'h77);
        do_rd(BASE + 16'd1, "R10 undefined index reads 0");
        // R5
        reg_wr(8'h02, 8'hFD);
        check_outs("R5 no leave without bit 1");
        do_rd(BASE + 16'd1, "R5 command reads 0");
        do_wr(BASE + 16'd1, 8'h02);
        check_outs("R5 leave drops active");
        reg_wr(8'h23, 8'h01);
        check_outs("R5 writes ignored after leave");
        do_rd(BASE, "R5 reads float after leave");
        set_mode(0);
        set_mode(1);
        check_outs("R5 re-entry restores active");
        // random phase
        for (int k = 0; k < 3000; k++) begin
            int unsigned r;
            r = $urandom % 20;
            if (r < 6) begin
                case ($urandom % 6)
                    0: pick = 8'h07;
                    1: pick = 8'h23;
                    2: pick = 8'h24;
                    3: pick = 8'h02;
                    4: pick = 8'($urandom);
                    default: pick = 8'h30 + 8'($urandom % 16);
                endcase
                do_wr(BASE, pick);
            end else if (r < 12) begin
                pick = 8'($urandom);
                if (m_idx == 8'h07) pick = 8'($urandom % 10);
                if (m_idx == 8'h02 && ($urandom % 8) != 0) pick[1] = 1'b0;
                do_wr(BASE + 16'd1, pick);
                check_outs("R11 random write outputs");
            end else if (r < 18) begin
                do_rd(BASE + 16'd1, "R4 random data read");
            end else if (r == 18) begin
                do_rd(BASE, "R2 random index read");
            end else begin
                set_mode(!cfg_mode || m_hold);
                check_outs("R3 random mode change");
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule